// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Unit

This block times the rotation of a cooling fan from the pulse train on its tach wire. Several tach wires come into the block. Software picks one of them by changing a trigger mask from zero to a value with a single bit set. The block then waits for a qualifying edge on that wire and counts ticks of a divided "tach clock" until the interval closes. It reports the count in a result word, with a completion flag in the top bit.

Software chooses which edges qualify: falling, rising, or both. The tach clock divides the core clock by four times a power of four, and a 2-bit divider code sets that power. Each wire first passes through a two-stage synchronizer. The count saturates instead of wrapping. A watchdog on the tach tick count ends a stalled measurement with a count of zero. Any measurement on a wire whose enable bit is clear stays open indefinitely. Conversion of the count to a rotation speed is left to software.

Top module: `tach_meter`

## Requirements
- R1: After reset the result word is all zeros (done flag 0, count 0).
- R2: A change of the trigger mask in which exactly one bit goes from 0 to 1 starts a measurement on that channel, and on the next clock the done flag and the count read 0. A change in which zero bits, or two or more bits, go from 0 to 1 is ignored and leaves the result word unchanged.
- R3: In the 32-bit result word, bit 31 is the done flag and bits [CNT_W-1:0] hold the count (CNT_W is 20 by default). All other bits are zero, and the count reads 0 while the done flag is 0.
- R4: In single-edge modes one tach tick lasts 4 << (2 × divider code) core clock cycles: 4, 16, 64 or 256 cycles for codes 0 to 3. The tick divider restarts at each start.
- R5: In edge mode 00 (falling) or 01 (rising), the count is the number of ticks between two consecutive qualifying edges. For a tach period of P cycles, where P is a multiple of the tick length D, the count is P/D.
- R6: In edge mode 10 (both edges), the window opens on any edge and closes on the second edge after it, which is one full period. Ticks run at twice the single-edge rate, so the count is 2·P/D.
- R7: Edge mode 11 is reserved. No edge qualifies in this mode, so a measurement ends through the timeout (R9).
- R8: The count saturates at 2^CNT_W − 1 and does not wrap.
- R9: If 2^TMO_W tach ticks pass without the edge the measurement is waiting for, the measurement ends with the done flag set to 1 and a count of 0 (TMO_W is 20 by default).
- R10: While the enable bit of the selected channel is 0, the measurement neither counts nor times out, and the done flag stays 0.
- R11: Once the done flag is 1, the result word holds its value until the next valid start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tachIn | input | NUM_CH | Raw tach wires, asynchronous to clk |
| chanEn | input | NUM_CH | Per-channel enable |
| edgeMode | input | 2 | 00 falling, 01 rising, 10 both, 11 reserved |
| divCode | input | DIV_W | Tach clock divider code |
| trigMask | input | NUM_CH | One-hot trigger mask, set after writing 0 |
| resultWord | output | 32 | Done flag in bit 31, count in [CNT_W-1:0] |

## Verification
Two things can fall on the same clock: a tach tick and the edge that closes the window. That tick must still be counted. The bench repeats one fixed tach waveform and delays the trigger by zero to three cycles each time. This walks the restarted tick divider through every phase relative to the edges, so one run lands a tick exactly on the closing edge. Every run must return exactly P/D. A tick dropped on the closing edge would show up as one count short in exactly the phase that coincides.

// File: rtl/tach_pkg.sv
package tach_pkg;

  localparam logic [1:0] MODE_FALL = 2'b00;
  localparam logic [1:0] MODE_RISE = 2'b01;
  localparam logic [1:0] MODE_BOTH = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_WIN1,
    ST_WIN2
  } tachState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic clrWin;
    logic cntRun;
    logic tmrClr;
    logic tmrRun;
    logic finishOk;
    logic finishZero;
  } tachStrb_t;

endpackage

// File: rtl/tach_datapath.sv
module tach_datapath
  import tach_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 2,
  parameter int CNT_W  = 20,
  parameter int TMO_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tachIn,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [1:0]        edgeMode,
  input  logic [DIV_W-1:0]  divCode,
  input  logic [NUM_CH-1:0] trigMask,
  input  tachStrb_t         strb,
  output logic              startReq,
  output logic              qualEdge,
  output logic              timeoutHit,
  output logic              selEnabled,
  output logic [31:0]       resultWord
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PSC_W = 2 * ((1 << DIV_W) - 1) + 3;

  logic [NUM_CH-1:0] syncA, syncB;

  // two-stage synchronizer per tach wire
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        syncA[g] <= tachIn[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  // trigger rise detection
  logic [NUM_CH-1:0] trigPrev, trigRise;
  logic [IDX_W-1:0]  riseIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= '0;
    else       trigPrev <= trigMask;
  end
  assign trigRise = trigMask & ~trigPrev;
  assign startReq = $onehot(trigRise);

  always_comb begin
    riseIdx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (trigRise[i]) riseIdx = IDX_W'(i);
  end

  // channel select and edge detect
  logic [IDX_W-1:0] chSel;
  logic             selPrev, selLvl, selRise, selFall;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chSel   <= '0;
      selPrev <= 1'b0;
    end else if (strb.start) begin
      chSel   <= riseIdx;
      selPrev <= syncB[riseIdx];
    end else begin
      selPrev <= selLvl;
    end
  end
  assign selLvl     = syncB[chSel];
  assign selRise    = selLvl & ~selPrev;
  assign selFall    = ~selLvl & selPrev;
  assign selEnabled = chanEn[chSel];

  always_comb begin
    unique case (edgeMode)
      MODE_FALL: qualEdge = selFall;
      MODE_RISE: qualEdge = selRise;
      MODE_BOTH: qualEdge = selRise | selFall;
      default:   qualEdge = 1'b0;
    endcase
  end

  // tach tick prescaler
  logic [PSC_W-1:0] psc, pscTerm, pscBase;
  logic             tick, bothMode;
  assign bothMode = (edgeMode == MODE_BOTH);
  assign pscBase  = PSC_W'(4) << {divCode, 1'b0};
  assign pscTerm  = (pscBase >> bothMode) - PSC_W'(1);
  assign tick     = (psc == pscTerm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   psc <= '0;
    else if (strb.start || tick) psc <= '0;
    else                         psc <= psc + PSC_W'(1);
  end

  // window counter, saturating
  logic [CNT_W-1:0] winCnt, cntNext;
  logic             winSat;
  assign winSat  = &winCnt;
  assign cntNext = (tick && !winSat) ? winCnt + CNT_W'(1) : winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         winCnt <= '0;
    else if (strb.start || strb.clrWin) winCnt <= '0;
    else if (strb.cntRun)              winCnt <= cntNext;
  end

  // timeout timer in ticks
  logic [TMO_W:0] tmr;
  assign timeoutHit = tmr[TMO_W];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   tmr <= '0;
    else if (strb.start || strb.tmrClr)          tmr <= '0;
    else if (strb.tmrRun && tick && !timeoutHit) tmr <= tmr + (TMO_W+1)'(1);
  end

  // result register
  logic             doneReg;
  logic [CNT_W-1:0] countReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneReg  <= 1'b0;
      countReg <= '0;
    end else if (strb.start) begin
      doneReg  <= 1'b0;
      countReg <= '0;
    end else if (strb.finishOk) begin
      doneReg  <= 1'b1;
      countReg <= cntNext;
    end else if (strb.finishZero) begin
      doneReg  <= 1'b1;
      countReg <= '0;
    end
  end

  always_comb begin
    resultWord              = '0;
    resultWord[31]          = doneReg;
    resultWord[CNT_W-1:0]   = countReg;
  end

endmodule

// File: rtl/tach_control.sv
module tach_control
  import tach_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      qualEdge,
  input  logic      timeoutHit,
  input  logic      selEnabled,
  input  logic      bothMode,
  output tachStrb_t strb
);

  tachState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (startReq) begin
      strb.start = 1'b1;
      stateNext  = ST_ARM;
    end else if (state != ST_IDLE && selEnabled) begin
      strb.tmrRun = 1'b1;
      strb.cntRun = (state != ST_ARM);
      if (qualEdge) begin
        unique case (state)
          ST_ARM: begin
            strb.clrWin = 1'b1;
            strb.tmrClr = 1'b1;
            stateNext   = ST_WIN1;
          end
          ST_WIN1: begin
            if (bothMode) stateNext = ST_WIN2;
            else begin
              strb.finishOk = 1'b1;
              stateNext     = ST_IDLE;
            end
          end
          default: begin
            strb.finishOk = 1'b1;
            stateNext     = ST_IDLE;
          end
        endcase
      end else if (timeoutHit) begin
        strb.finishZero = 1'b1;
        stateNext       = ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/tach_meter.sv
module tach_meter
  import tach_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 2,
  parameter int CNT_W  = 20,
  parameter int TMO_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tachIn,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [1:0]        edgeMode,
  input  logic [DIV_W-1:0]  divCode,
  input  logic [NUM_CH-1:0] trigMask,
  output logic [31:0]       resultWord
);

  tachStrb_t strb;
  logic      startReq, qualEdge, timeoutHit, selEnabled;

  tach_datapath #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W), .CNT_W(CNT_W), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .chanEn(chanEn),
    .edgeMode(edgeMode), .divCode(divCode), .trigMask(trigMask),
    .strb(strb), .startReq(startReq), .qualEdge(qualEdge),
    .timeoutHit(timeoutHit), .selEnabled(selEnabled),
    .resultWord(resultWord)
  );

  tach_control u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .qualEdge(qualEdge),
    .timeoutHit(timeoutHit), .selEnabled(selEnabled),
    .bothMode(edgeMode == MODE_BOTH), .strb(strb)
  );

endmodule

// File: rtl/tach_meter_chk.sv
module tach_meter_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chanEn,
  input logic [NUM_CH-1:0] trigMask,
  input logic [31:0]       resultWord
);

  logic [NUM_CH-1:0] trigSeen, trigUp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigSeen <= '0;
    else       trigSeen <= trigMask;
  end
  assign trigUp = trigMask & ~trigSeen;

  // R1: result is clear when reset is released
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> resultWord == 32'd0);

  // R2: a valid start clears done and count on the next clock
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(trigUp) |=> (resultWord[31] == 1'b0 && resultWord[CNT_W-1:0] == '0));

  // R3: count reads zero while not done
  p_count_zero_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    !resultWord[31] |-> resultWord[CNT_W-1:0] == '0);

  // R10: with every channel disabled, a pending measurement stays pending
  p_disabled_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn == '0 && !resultWord[31]) |=> !resultWord[31]);

  // R11: a completed result holds until a valid start
  p_done_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (resultWord[31] && !$onehot(trigUp)) |=> $stable(resultWord));

endmodule

bind tach_meter tach_meter_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .trigMask(trigMask),
  .resultWord(resultWord)
);

// File: tb/test_tach_meter.sv
module test_tach_meter;

  localparam int NUM_CH = 4;
  localparam int DIV_W  = 2;
  localparam int CNT_W  = 6;
  localparam int TMO_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] tachIn = '0;
  logic [NUM_CH-1:0] chanEn = '0;
  logic [1:0]        edgeMode = 2'b00;
  logic [DIV_W-1:0]  divCode = '0;
  logic [NUM_CH-1:0] trigMask = '0;
  logic [31:0]       resultWord;

  int nChecks = 0;
  int nFails  = 0;

  always #10ns clk = ~clk;

  tach_meter #(.NUM_CH(NUM_CH), .DIV_W(DIV_W), .CNT_W(CNT_W), .TMO_W(TMO_W))
    i_tach_meter (
      .clk(clk), .rstN(rstN), .tachIn(tachIn), .chanEn(chanEn),
      .edgeMode(edgeMode), .divCode(divCode), .trigMask(trigMask),
      .resultWord(resultWord)
    );

  // tach waveform generators: hiT == 0 freezes the wire
  int hiT[NUM_CH];
  int loT[NUM_CH];
  int ctr[NUM_CH];
  initial for (int i = 0; i < NUM_CH; i++) begin hiT[i] = 0; loT[i] = 0; ctr[i] = 0; end

  always @(negedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (hiT[c] != 0) begin
        ctr[c] = ctr[c] + 1;
        if (tachIn[c] && ctr[c] >= hiT[c]) begin tachIn[c] = 1'b0; ctr[c] = 0; end
        else if (!tachIn[c] && ctr[c] >= loT[c]) begin tachIn[c] = 1'b1; ctr[c] = 0; end
      end
    end
  end

  typedef struct packed {
    int ch; int mode; int dcode; int hi; int lo; int expCnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{0, 0, 0,  20,  20, 10},   // R5 falling, tick 4
    '{1, 1, 1,  40,  40,  5},   // R4 R5 rising, tick 16
    '{2, 2, 0,  20,  44, 32},   // R6 both, tick 2, asymmetric
    '{3, 0, 0,  10,  30, 10},   // R5 falling, asymmetric
    '{0, 1, 2, 128, 128,  4},   // R4 rising, tick 64
    '{1, 2, 1,  24,  40,  8},   // R6 both, tick 8
    '{2, 0, 0, 200, 200, CMAX}  // R8 saturation
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic trigger(input int ch);
    @(negedge clk); trigMask = '0;
    @(negedge clk); @(negedge clk);
    trigMask = NUM_CH'(1) << ch;
  endtask

  task automatic waitDone(input int maxCyc);
    for (int k = 0; k < maxCyc; k++) begin
      @(negedge clk);
      if (resultWord[31]) break;
    end
  endtask

  task automatic setup(input int ch, input int mode, input int dcode, input int hi, input int lo);
    edgeMode = 2'(mode);
    divCode  = DIV_W'(dcode);
    hiT[ch]  = hi;
    loT[ch]  = lo;
  endtask

  initial begin
    #(20ns * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int savedCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(resultWord == 32'd0, "R1 reset result", int'(resultWord), 0);
    chanEn = '1;

    // table of vectors
    foreach (VECS[v]) begin
      setup(VECS[v].ch, VECS[v].mode, VECS[v].dcode, VECS[v].hi, VECS[v].lo);
      repeat (5) @(negedge clk);
      trigger(VECS[v].ch);
      waitDone(6000);
      check(resultWord[31] == 1'b1, "R5/R6 done flag", int'(resultWord[31]), 1);
      check(int'(resultWord[19:0]) == VECS[v].expCnt, "R4 R5 R6 R8 count",
            int'(resultWord[19:0]), VECS[v].expCnt);
      check(resultWord[30:20] == '0, "R3 pad bits", int'(resultWord[30:20]), 0);
    end

    // R2: new start clears done and count
    trigger(0);
    @(negedge clk);
    check(resultWord == 32'd0, "R2 start clears result", int'(resultWord), 0);
    waitDone(6000);

    // phase sweep: a tick landing on the closing edge must be counted
    setup(0, 0, 0, 20, 20);
    for (int off = 0; off < 4; off++) begin
      @(negedge clk); trigMask = '0;
      repeat (2 + off) @(negedge clk);
      trigMask = NUM_CH'(1);
      waitDone(6000);
      check(int'(resultWord[19:0]) == 10, "R5 tick on closing edge",
            int'(resultWord[19:0]), 10);
    end

    // R2: non-one-hot trigger ignored
    savedCnt = int'(resultWord[19:0]);
    @(negedge clk); trigMask = '0;
    repeat (2) @(negedge clk);
    trigMask = 4'b0110;
    repeat (300) @(negedge clk);
    check(resultWord[31] == 1'b1 && int'(resultWord[19:0]) == savedCnt,
          "R2 R11 multi-bit trigger ignored", int'(resultWord[19:0]), savedCnt);

    // R9: frozen tach ends with zero count
    hiT[3] = 0;
    edgeMode = 2'b00; divCode = '0;
    trigger(3);
    waitDone(6000);
    check(resultWord[31] == 1'b1, "R9 timeout done", int'(resultWord[31]), 1);
    check(resultWord[19:0] == '0, "R9 timeout count", int'(resultWord[19:0]), 0);

    // R7: reserved mode qualifies no edge
    setup(1, 3, 0, 10, 10);
    trigger(1);
    repeat (200) @(negedge clk);
    check(resultWord[31] == 1'b0, "R7 reserved pending", int'(resultWord[31]), 0);
    waitDone(6000);
    check(resultWord[31] == 1'b1 && resultWord[19:0] == '0, "R7 reserved zero",
          int'(resultWord[19:0]), 0);

    // R10: disabled channel never completes
    setup(2, 0, 0, 10, 10);
    chanEn = 4'b1011;
    trigger(2);
    repeat (3000) @(negedge clk);
    check(resultWord[31] == 1'b0, "R10 disabled no done", int'(resultWord[31]), 0);
    chanEn = '1;
    waitDone(6000);
    check(int'(resultWord[19:0]) == 5, "R10 resumes when enabled",
          int'(resultWord[19:0]), 5);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule